// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block runs one complete I2C message on a byte-level I2C engine with no processor in the loop. The engine raises an interrupt after each bus event and presents a status code. The sequencer reads that code and decides the next step. It can send the first or the second address byte, push a data byte, ask for another received byte, or close the transfer with a STOP. The status code alone selects the branch. The message parameters and the abort request only refine the choice.

The user pulses `start` with a 7-bit or 10-bit target address, a direction, a byte count and a no-start option. Write data enters on a valid/ready stream: a byte moves on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the sequencer is waiting for the next byte to send. Read data leaves on a second valid/ready stream. While `rx_ready` is low, `rx_valid` and `rx_data` hold steady, and the engine is not released until the byte has been taken. Back-pressure on either stream therefore stretches the bus transfer, and no byte is ever dropped.

The message ends with a one-cycle `done` pulse and a result code. Two ways exist to abort a message: the `abort_req` input and a built-in timeout. When the timeout expires a second time, the sequencer forces the engine through a soft reset.

Top module: `i2c_msg_seq`

## Requirements
- R1: For a 7-bit message the first address byte sent to the engine is {addr[6:0], rd}, where rd is 1 for a read, and no second address byte is sent.
- R2: For a 10-bit message the first address byte is {5'b11110, addr[9:8], rd}. After status 0x18 or 0x40 the sequencer writes the second address byte addr[7:0]. After 0x08 or 0x10 it writes the first address byte.
- R3: Accepting a message without the no-start option issues one control write of value 5'b11101. The control bit positions are [0] ACK, [1] STOP, [2] START, [3] engine enable, [4] interrupt enable.
- R4: On status 0x18 (7-bit), 0xD0 or 0x28 with bytes remaining, one byte is taken from the tx stream and written to the engine with a control write. When no bytes remain, the message ends with result OK (code 0).
- R5: On status 0x50 the received byte appears on the rx stream and is held until accepted. Every control write that requests a further byte has ACK = 1, except the request for the final byte, which has ACK = 0.
- R6: On status 0x58 the last byte is delivered on the rx stream. A STOP write of value 5'b01010 and `done` follow.
- R7: A read of zero bytes ends with STOP and result OK as soon as the address is acknowledged (0x40 or 0xE0).
- R8: Status 0x20, 0x30 or 0x48 ends the message with STOP and result no-device (code 1).
- R9: Any other status pulses `eng_srst` for one cycle. In the next cycle the sequencer writes 5'b01010 and ends with result I/O error (code 2).
- R10: With the no-start option, START and address are skipped. A write sends its first tx byte at once. A read issues a byte-request control write at once.
- R11: An engine interrupt while the sequencer is idle produces only a STOP write (5'b01010), with no `done`.
- R12: Under an abort request, a write stops at the next acknowledged byte once at least one data byte has gone out. A read NACKs the next byte. Either way the result is aborted (code 3).
- R13: While busy, after TMO_CYC cycles the timeout acts as an abort request. After 2·TMO_CYC cycles the sequencer pulses `eng_srst`, writes STOP and ends with result aborted.
- R14: Every control write carries the engine-enable bit, a STOP write never carries START or interrupt enable, and `done` is a single-cycle pulse seen with `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a message (taken while idle) |
| msg_addr | input | 10 | Target address |
| msg_ten | input | 1 | 1 selects 10-bit addressing |
| msg_rd | input | 1 | 1 for read, 0 for write |
| msg_len | input | LEN_W | Number of data bytes |
| msg_nostart | input | 1 | Skip START and address phases |
| abort_req | input | 1 | Request a graceful abort |
| busy | output | 1 | A message is in progress |
| done | output | 1 | One-cycle end-of-message pulse |
| result | output | 2 | 0 OK, 1 no-device, 2 I/O error, 3 aborted |
| tx_valid | input | 1 | Write byte available |
| tx_ready | output | 1 | Sequencer takes a write byte |
| tx_data | input | 8 | Write byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Received byte |
| eng_irq | input | 1 | Engine interrupt flag |
| eng_status | input | 8 | Engine status code |
| eng_rdata | input | 8 | Engine received byte |
| eng_ctl_wr | output | 1 | Control register write strobe |
| eng_ctl | output | 5 | Control value written |
| eng_data_wr | output | 1 | Data register write strobe |
| eng_wdata | output | 8 | Data byte written |
| eng_srst | output | 1 | Engine soft reset pulse |

## Verification
The assertions assume an engine that drops its interrupt flag in the cycle after it sees a control write or a soft reset. They also assume the engine raises no interrupt after a STOP unless something pokes it. The bench engine model obeys both rules: it raises interrupts a fixed few cycles after each write and clears them on the write edge. The model is scripted so that the target is present or absent, a chosen data byte is NACKed, the start answers with an unexpected code, or the engine never answers. The `start` and message inputs change only while `busy` is low, and `abort_req` is held for the whole message it aborts. Stream valid and ready are toggled at random on the falling edge, so back-pressure occurs at every stage.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int CTL_W    = 5;
  localparam int CB_ACK   = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_START = 2;
  localparam int CB_EN    = 3;
  localparam int CB_IEN   = 4;

  localparam logic [CTL_W-1:0] CTL_RUN  = CTL_W'((1 << CB_IEN) | (1 << CB_EN));
  localparam logic [CTL_W-1:0] CTL_HALT = CTL_W'((1 << CB_EN) | (1 << CB_STOP));

  localparam logic [7:0] ST_START    = 8'h08;
  localparam logic [7:0] ST_RESTART  = 8'h10;
  localparam logic [7:0] ST_WA_ACK   = 8'h18;
  localparam logic [7:0] ST_WA_NACK  = 8'h20;
  localparam logic [7:0] ST_WD_ACK   = 8'h28;
  localparam logic [7:0] ST_WD_NACK  = 8'h30;
  localparam logic [7:0] ST_RA_ACK   = 8'h40;
  localparam logic [7:0] ST_RA_NACK  = 8'h48;
  localparam logic [7:0] ST_RD_ACK   = 8'h50;
  localparam logic [7:0] ST_RD_NACK  = 8'h58;
  localparam logic [7:0] ST_WA2_ACK  = 8'hD0;
  localparam logic [7:0] ST_RA2_ACK  = 8'hE0;

  typedef enum logic [1:0] {RES_OK, RES_NODEV, RES_IOERR, RES_ABORT} res_e;

  typedef enum logic [3:0] {
    A_ADDR1, A_ADDR2, A_SEND, A_FINISH, A_CONT, A_RECV, A_RECV_LAST, A_NODEV, A_ERR
  } act_e;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_TXGET, S_RXPUT, S_FIN} seq_state_e;
endpackage

// File: rtl/i2cseq_addrfmt.sv
module i2cseq_addrfmt (
  input  logic [9:0] addr,
  input  logic       ten,
  input  logic       rd,
  output logic [7:0] first,
  output logic [7:0] second
);
  always_comb begin
    if (ten) begin
      first  = {5'b11110, addr[9:8], rd};
      second = addr[7:0];
    end else begin
      first  = {addr[6:0], rd};
      second = 8'h00;
    end
  end
endmodule

// File: rtl/i2cseq_decode.sv
module i2cseq_decode
  import i2cseq_pkg::*;
(
  input  logic [7:0] status,
  input  logic       ten,
  input  logic       left_zero,
  input  logic       abort,
  input  logic       sent_any,
  output act_e       act
);
  act_e wr_next, rd_first;

  always_comb begin
    wr_next  = (left_zero || (abort && sent_any)) ? A_FINISH : A_SEND;
    rd_first = left_zero ? A_FINISH : A_CONT;
    case (status)
      ST_START, ST_RESTART:              act = A_ADDR1;
      ST_WA_ACK:                         act = ten ? A_ADDR2 : wr_next;
      ST_WA2_ACK, ST_WD_ACK:             act = wr_next;
      ST_RA_ACK:                         act = ten ? A_ADDR2 : rd_first;
      ST_RA2_ACK:                        act = rd_first;
      ST_RD_ACK:                         act = A_RECV;
      ST_RD_NACK:                        act = A_RECV_LAST;
      ST_WA_NACK, ST_WD_NACK, ST_RA_NACK: act = A_NODEV;
      default:                           act = A_ERR;
    endcase
  end
endmodule

// File: rtl/i2cseq_watch.sv
module i2cseq_watch #(
  parameter int TMO_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic abort_o,
  output logic kill_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt;
  logic          stage;
  logic          wrap;

  assign wrap    = run && (cnt == LAST);
  assign abort_o = stage;
  assign kill_o  = wrap && stage;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      stage <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      stage <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_msg_seq.sv
module i2c_msg_seq
  import i2cseq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       msg_addr,
  input  logic             msg_ten,
  input  logic             msg_rd,
  input  logic [LEN_W-1:0] msg_len,
  input  logic             msg_nostart,
  input  logic             abort_req,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  input  logic             eng_irq,
  input  logic [7:0]       eng_status,
  input  logic [7:0]       eng_rdata,
  output logic             eng_ctl_wr,
  output logic [CTL_W-1:0] eng_ctl,
  output logic             eng_data_wr,
  output logic [7:0]       eng_wdata,
  output logic             eng_srst
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

  seq_state_e       state;
  logic [LEN_W-1:0] left;
  logic             sent_any, abort_r, ack_r, ten_r, rd_r, rx_last;
  logic [9:0]       addr_r;
  res_e             fin_res;
  logic [7:0]       a1, a2;
  act_e             act;
  logic             abort_eff, tmo_abort, tmo_kill, irq_new;

  assign busy      = (state != S_IDLE);
  assign tx_ready  = (state == S_TXGET);
  assign irq_new   = eng_irq && !eng_ctl_wr;
  assign abort_eff = abort_r || abort_req || tmo_abort;

  i2cseq_addrfmt u_addr (
    .addr(addr_r), .ten(ten_r), .rd(rd_r), .first(a1), .second(a2)
  );

  i2cseq_decode u_dec (
    .status(eng_status), .ten(ten_r), .left_zero(left == '0),
    .abort(abort_eff), .sent_any(sent_any), .act(act)
  );

  i2cseq_watch #(.TMO_CYC(TMO_CYC)) u_watch (
    .clk(clk), .rst_n(rst_n), .run(busy), .abort_o(tmo_abort), .kill_o(tmo_kill)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      left        <= '0;
      sent_any    <= 1'b0;
      abort_r     <= 1'b0;
      ack_r       <= 1'b1;
      ten_r       <= 1'b0;
      rd_r        <= 1'b0;
      rx_last     <= 1'b0;
      addr_r      <= '0;
      fin_res     <= RES_OK;
      done        <= 1'b0;
      result      <= 2'd0;
      rx_valid    <= 1'b0;
      rx_data     <= 8'h00;
      eng_ctl_wr  <= 1'b0;
      eng_ctl     <= '0;
      eng_data_wr <= 1'b0;
      eng_wdata   <= 8'h00;
      eng_srst    <= 1'b0;
    end else begin
      eng_ctl_wr  <= 1'b0;
      eng_data_wr <= 1'b0;
      eng_srst    <= 1'b0;
      done        <= 1'b0;
      if (busy) abort_r <= abort_eff;

      if (tmo_kill && state != S_FIN) begin
        eng_srst <= 1'b1;
        rx_valid <= 1'b0;
        fin_res  <= RES_ABORT;
        state    <= S_FIN;
      end else begin
        case (state)
          S_IDLE: begin
            if (start) begin
              addr_r   <= msg_addr;
              ten_r    <= msg_ten;
              rd_r     <= msg_rd;
              left     <= msg_len;
              sent_any <= 1'b0;
              abort_r  <= 1'b0;
              ack_r    <= 1'b1;
              if (!msg_nostart) begin
                eng_ctl_wr <= 1'b1;
                eng_ctl    <= CTL_RUN | CTL_W'(1 << CB_ACK) | CTL_W'(1 << CB_START);
                state      <= S_WAIT;
              end else if (msg_rd) begin
                ack_r      <= (msg_len != ONE);
                eng_ctl_wr <= 1'b1;
                eng_ctl    <= CTL_RUN | CTL_W'(msg_len != ONE);
                state      <= S_WAIT;
              end else begin
                left     <= msg_len - LEN_W'(msg_len != '0);
                sent_any <= 1'b1;
                state    <= S_TXGET;
              end
            end else if (irq_new) begin
              eng_ctl_wr <= 1'b1;
              eng_ctl    <= CTL_HALT;
            end
          end

          S_WAIT: begin
            if (irq_new) begin
              case (act)
                A_ADDR1, A_ADDR2: begin
                  eng_data_wr <= 1'b1;
                  eng_wdata   <= (act == A_ADDR1) ? a1 : a2;
                  eng_ctl_wr  <= 1'b1;
                  eng_ctl     <= CTL_RUN | CTL_W'(ack_r);
                end
                A_SEND: begin
                  left     <= left - ONE;
                  sent_any <= 1'b1;
                  state    <= S_TXGET;
                end
                A_CONT: begin
                  ack_r      <= !((left == ONE) || abort_eff);
                  eng_ctl_wr <= 1'b1;
                  eng_ctl    <= CTL_RUN | CTL_W'(!((left == ONE) || abort_eff));
                end
                A_RECV, A_RECV_LAST: begin
                  if (act == A_RECV) begin
                    left  <= left - ONE;
                    ack_r <= !((left == TWO) || abort_eff);
                  end
                  rx_data  <= eng_rdata;
                  rx_valid <= 1'b1;
                  rx_last  <= (act == A_RECV_LAST);
                  state    <= S_RXPUT;
                end
                A_FINISH: begin
                  fin_res <= abort_eff ? RES_ABORT : RES_OK;
                  state   <= S_FIN;
                end
                A_NODEV: begin
                  fin_res <= RES_NODEV;
                  state   <= S_FIN;
                end
                default: begin
                  eng_srst <= 1'b1;
                  fin_res  <= RES_IOERR;
                  state    <= S_FIN;
                end
              endcase
            end
          end

          S_TXGET: begin
            if (tx_valid) begin
              eng_data_wr <= 1'b1;
              eng_wdata   <= tx_data;
              eng_ctl_wr  <= 1'b1;
              eng_ctl     <= CTL_RUN | CTL_W'(ack_r);
              state       <= S_WAIT;
            end
          end

          S_RXPUT: begin
            if (rx_ready) begin
              rx_valid <= 1'b0;
              if (rx_last) begin
                fin_res <= abort_eff ? RES_ABORT : RES_OK;
                state   <= S_FIN;
              end else begin
                eng_ctl_wr <= 1'b1;
                eng_ctl    <= CTL_RUN | CTL_W'(ack_r);
                state      <= S_WAIT;
              end
            end
          end

          default: begin
            eng_ctl_wr <= 1'b1;
            eng_ctl    <= CTL_HALT;
            done       <= 1'b1;
            result     <= 2'(fin_res);
            state      <= S_IDLE;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk
  import i2cseq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             msg_nostart,
  input logic             busy,
  input logic             done,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       rx_data,
  input logic             eng_irq,
  input logic             eng_ctl_wr,
  input logic [CTL_W-1:0] eng_ctl,
  input logic             eng_srst
);
  assert_start_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !msg_nostart) |=> (eng_ctl_wr && eng_ctl[CB_START]));

  assert_stream_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_ready && rx_valid));

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_srst_then_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_srst |=> (eng_ctl_wr && eng_ctl == CTL_HALT));

  assert_idle_irq_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && eng_irq && !eng_ctl_wr) |=> (eng_ctl_wr && eng_ctl == CTL_HALT && !done));

  assert_ctl_enable_R14: assert property (@(posedge clk) disable iff (!rst_n)
    eng_ctl_wr |-> eng_ctl[CB_EN]);

  assert_stop_clean_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ctl_wr && eng_ctl[CB_STOP]) |-> (!eng_ctl[CB_START] && !eng_ctl[CB_IEN]));

  assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_stop_R14: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (eng_ctl_wr && eng_ctl == CTL_HALT && !busy));
endmodule

bind i2c_msg_seq i2cseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .msg_nostart(msg_nostart),
  .busy(busy), .done(done), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .eng_irq(eng_irq),
  .eng_ctl_wr(eng_ctl_wr), .eng_ctl(eng_ctl), .eng_srst(eng_srst)
);

// File: tb/i2c_msg_seq_test.sv
`timescale 1ns/1ps
module i2c_msg_seq_test;
  localparam int LEN_W = 8;
  localparam int TMO   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [9:0] msg_addr = '0;
  logic msg_ten = 1'b0, msg_rd = 1'b0, msg_nostart = 1'b0, abort_req = 1'b0;
  logic [LEN_W-1:0] msg_len = '0;
  logic busy, done, tx_ready, rx_valid, eng_ctl_wr, eng_data_wr, eng_srst;
  logic [1:0] result;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data, eng_wdata;
  logic [4:0] eng_ctl;
  logic eng_irq = 1'b0;
  logic [7:0] eng_status = 8'hF8, eng_rdata = 8'h00;

  i2c_msg_seq #(.LEN_W(LEN_W), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_addr(msg_addr), .msg_ten(msg_ten),
    .msg_rd(msg_rd), .msg_len(msg_len), .msg_nostart(msg_nostart), .abort_req(abort_req),
    .busy(busy), .done(done), .result(result), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .eng_irq(eng_irq), .eng_status(eng_status), .eng_rdata(eng_rdata),
    .eng_ctl_wr(eng_ctl_wr), .eng_ctl(eng_ctl), .eng_data_wr(eng_data_wr),
    .eng_wdata(eng_wdata), .eng_srst(eng_srst)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  // engine model configuration and logs
  bit cfg_present = 1, cfg_err = 0, cfg_stall = 0, poke = 0;
  int cfg_nack = -1;
  int e_ph = 0, e_dly = 0, e_dn = 0, e_rn = 0;
  logic [7:0] e_pend = 8'h00;
  logic [7:0] txlog [0:31];
  bit ackl [0:31];
  logic [7:0] rxlog [0:31];
  int txn = 0, ackn = 0, rxn = 0, stops = 0, srsts = 0, dones = 0, txidx = 0;
  logic [4:0] first_ctl = '0;
  bit first_seen = 0;
  logic [1:0] got_res = '0;

  task automatic sched(input logic [7:0] code);
    e_pend = code;
    e_dly  = 3;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (e_dly > 0) begin
        e_dly--;
        if (e_dly == 0) begin
          eng_irq    <= 1'b1;
          eng_status <= e_pend;
        end
      end
      if (poke) begin
        poke = 0;
        sched(8'h28);
      end
      if (tx_valid && tx_ready) txidx++;
      if (rx_valid && rx_ready && rxn < 32) begin rxlog[rxn] = rx_data; rxn++; end
      if (done) begin dones++; got_res = result; end
      if (eng_srst) begin srsts++; eng_irq <= 1'b0; e_dly = 0; end
      if (eng_ctl_wr) begin
        eng_irq <= 1'b0;
        if (!first_seen) begin first_seen = 1; first_ctl = eng_ctl; end
        if (eng_ctl[1]) stops++;
        else if (eng_ctl[2]) begin
          e_ph = 1;
          if (!cfg_stall) sched(cfg_err ? 8'h38 : 8'h08);
        end else if (eng_data_wr) begin
          if (txn < 32) begin txlog[txn] = eng_wdata; txn++; end
          if (e_ph == 1) begin
            if (!cfg_present) sched(msg_rd ? 8'h48 : 8'h20);
            else begin
              e_ph = msg_ten ? 2 : 3;
              sched(msg_rd ? 8'h40 : 8'h18);
            end
          end else if (e_ph == 2) begin
            e_ph = 3;
            sched(msg_rd ? 8'hE0 : 8'hD0);
          end else begin
            sched((e_dn == cfg_nack) ? 8'h30 : 8'h28);
            e_dn++;
          end
        end else begin
          if (ackn < 32) begin ackl[ackn] = eng_ctl[0]; ackn++; end
          eng_rdata <= 8'hA0 + 8'(e_rn);
          e_rn++;
          sched(eng_ctl[0] ? 8'h50 : 8'h58);
        end
      end
    end
  end

  // randomized stream handshakes
  always @(negedge clk) begin
    rx_ready <= ($urandom % 4) != 0;
    tx_valid <= ($urandom % 3) != 0;
    tx_data  <= 8'h30 + 8'(txidx);
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_a1(input logic [9:0] a, input bit ten, input bit rd);
    if (ten) return {5'b11110, a[9:8], rd};
    return {a[6:0], rd};
  endfunction

  // run one message; nd = data bytes expected to move (write) or be received (read)
  task automatic run_msg(input string tag, input logic [9:0] a, input bit ten, input bit rd,
                         input bit ns, input int len, input bit present, input int nack,
                         input bit err, input bit stall, input bit abrt,
                         input int nd, input logic [1:0] exp_res);
    int naddr, ntx, waited;
    logic [7:0] e;
    bit ok;
    @(negedge clk);
    cfg_present = present; cfg_nack = nack; cfg_err = err; cfg_stall = stall;
    e_ph = ns ? 3 : 0; e_dn = 0; e_rn = 0;
    txn = 0; ackn = 0; rxn = 0; stops = 0; srsts = 0; dones = 0; txidx = 0; first_seen = 0;
    msg_addr = a; msg_ten = ten; msg_rd = rd; msg_nostart = ns; msg_len = LEN_W'(len);
    abort_req = abrt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (dones == 0 && waited < 3000) begin @(negedge clk); waited++; end
    repeat (3) @(negedge clk);
    abort_req = 1'b0;
    chk(dones == 1, {tag, " R14 done count"}, dones, 1);
    chk(got_res == exp_res, {tag, " result"}, got_res, exp_res);
    chk(stops == 1, {tag, " R14 single stop"}, stops, 1);
    chk(srsts == ((err || stall) ? 1 : 0), {tag, " R9/R13 soft reset"}, srsts, (err || stall) ? 1 : 0);
    if (!ns && !stall) chk(first_ctl == 5'b11101, {tag, " R3 start ctl"}, first_ctl, 5'b11101);
    naddr = (ns || err || stall) ? 0 : ((present && ten) ? 2 : 1);
    ntx = naddr + (rd ? 0 : nd);
    chk(txn == ntx, {tag, " R1/R2/R4 tx count"}, txn, ntx);
    ok = 1;
    for (int i = 0; i < ntx && i < txn; i++) begin
      if (i == 0 && naddr > 0) e = exp_a1(a, ten, rd);
      else if (i == 1 && naddr == 2) e = a[7:0];
      else e = 8'h30 + 8'(i - naddr);
      if (txlog[i] !== e) begin
        ok = 0;
        chk(0, {tag, " R1/R2/R4 tx byte"}, txlog[i], e);
      end
    end
    if (ok) chk(1, {tag, " R1/R2/R4 tx bytes"}, 0, 0);
    if (rd) begin
      chk(rxn == nd, {tag, " R5/R6 rx count"}, rxn, nd);
      chk(ackn == nd, {tag, " R5 ack count"}, ackn, nd);
      for (int i = 0; i < nd && i < rxn; i++)
        chk(rxlog[i] == 8'hA0 + 8'(i), {tag, " R5/R6 rx byte"}, rxlog[i], 8'hA0 + i);
      for (int i = 0; i < nd && i < ackn; i++)
        chk(ackl[i] == ((i < nd - 1) && !abrt), {tag, " R5/R12 ack bit"}, ackl[i],
            (i < nd - 1) && !abrt);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !tx_ready && !rx_valid && !eng_ctl_wr, "reset state",
        {busy, done, tx_ready, rx_valid, eng_ctl_wr}, 0);

    // R11: stray interrupt while idle
    stops = 0; dones = 0;
    poke = 1;
    repeat (10) @(negedge clk);
    chk(stops == 1, "R11 idle irq stop", stops, 1);
    chk(dones == 0, "R11 idle irq no done", dones, 0);

    // directed corner cases
    run_msg("R1 write7", 10'h05A, 0, 0, 0, 3, 1, -1, 0, 0, 0, 3, 2'd0);
    run_msg("R2 read10", 10'h2C7, 1, 1, 0, 2, 1, -1, 0, 0, 0, 2, 2'd0);
    run_msg("R2 write10", 10'h1F3, 1, 0, 0, 2, 1, -1, 0, 0, 0, 2, 2'd0);
    run_msg("R7 read0", 10'h011, 0, 1, 0, 0, 1, -1, 0, 0, 0, 0, 2'd0);
    run_msg("R6 read1", 10'h022, 0, 1, 0, 1, 1, -1, 0, 0, 0, 1, 2'd0);
    run_msg("R4 write0", 10'h033, 0, 0, 0, 0, 1, -1, 0, 0, 0, 0, 2'd0);
    run_msg("R8 absent write", 10'h044, 0, 0, 0, 2, 0, -1, 0, 0, 0, 0, 2'd1);
    run_msg("R8 absent read10", 10'h355, 1, 1, 0, 2, 0, -1, 0, 0, 0, 0, 2'd1);
    run_msg("R8 data nack", 10'h066, 0, 0, 0, 4, 1, 1, 0, 0, 0, 2, 2'd1);
    run_msg("R9 bad status", 10'h077, 0, 0, 0, 2, 1, -1, 1, 0, 0, 0, 2'd2);
    run_msg("R10 nostart write", 10'h000, 0, 0, 1, 3, 1, -1, 0, 0, 0, 3, 2'd0);
    run_msg("R10 nostart read", 10'h000, 0, 1, 1, 3, 1, -1, 0, 0, 0, 3, 2'd0);
    run_msg("R12 abort write", 10'h088, 0, 0, 0, 4, 1, -1, 0, 0, 1, 1, 2'd3);
    run_msg("R12 abort read", 10'h099, 0, 1, 0, 3, 1, -1, 0, 0, 1, 1, 2'd3);
    run_msg("R13 timeout", 10'h0AA, 0, 0, 0, 2, 1, -1, 0, 1, 0, 0, 2'd3);

    // R1 R2 R4 R5: random complete messages under random back-pressure
    for (int k = 0; k < 30; k++) begin
      logic [9:0] a;
      bit ten, rd;
      int len;
      a   = 10'($urandom);
      ten = $urandom % 2;
      rd  = $urandom % 2;
      len = $urandom % 7;
      run_msg("R4/R5 random", a, ten, rd, 0, len, 1, -1, 0, 0, 0, len, 2'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule